// File: doc/BRIEF.md
# SDRAM Open-Row Bank Tracker

This block remembers, for every internal bank of an SDRAM device, whether a row is currently open and which row that is. A memory controller presents each access as a bank and row pair. The block answers in the same cycle with the commands that must be issued before the read or write can proceed:

- nothing, when the addressed row is already open;
- an ACTIVE command, when the bank is closed;
- a PRECHARGE followed by an ACTIVE, when a different row is open in that bank.

For an auto-refresh request, it reports whether a precharge-all command must be issued first.

The controller tells the tracker when ACTIVE, single-bank PRECHARGE or precharge-all commands have actually gone out on the device pins. The tracker updates its record on the next clock edge. The decision in any cycle is therefore taken from the record as it stood before that cycle's acknowledges. Command timing and the data path belong to the surrounding controller.

Top module: `sdram_row_tracker`

## Requirements
- R1: After reset every bank is recorded closed. A request to any bank then raises need_act and leaves need_pre low, and a refresh request leaves need_pre_all low.
- R2: A request to a closed bank gives need_act=1 and need_pre=0.
- R3: A request whose row equals the open row of its bank gives need_act=0 and need_pre=0.
- R4: A request to a bank that holds a different open row gives need_pre=1 and need_act=1. need_pre is never high without need_act.
- R5: A refresh request gives need_pre_all=1 exactly when at least one bank is open.
- R6: ack_act records bank ack_bank as open with row ack_row from the next cycle on.
- R7: ack_pre closes only bank ack_bank. Every other bank keeps its state and row.
- R8: ack_pre_all closes every bank.
- R9: When ack_act falls in the same cycle as ack_pre_all, or as ack_pre to the same bank, the ACTIVE is applied last. That bank ends open with ack_row, and all other closes still take effect.
- R10: Acknowledges take effect one cycle later. A request in the same cycle as an acknowledge is decided on the earlier record.
- R11: With req_valid low, need_act and need_pre are low. With ref_req low, need_pre_all is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Access request strobe |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| ref_req | input | 1 | Auto-refresh request |
| ack_act | input | 1 | ACTIVE issued to ack_bank with ack_row |
| ack_pre | input | 1 | Single-bank PRECHARGE issued to ack_bank |
| ack_pre_all | input | 1 | Precharge-all issued |
| ack_bank | input | BANK_W | Bank addressed by ack_act and ack_pre |
| ack_row | input | ROW_W | Row opened by ack_act |
| need_act | output | 1 | ACTIVE required before the access |
| need_pre | output | 1 | PRECHARGE required before the ACTIVE |
| need_pre_all | output | 1 | Precharge-all required before refresh |

## Verification
Two kinds of event can share a cycle: the lookup for a new request and the record update from an acknowledge. A command for the same bank can also be acknowledged at the moment another close lands. The bench provokes both cases. It uses directed cycles in which the request targets the very bank being opened or closed, and ack_act paired with ack_pre or ack_pre_all. It then follows with random sequences where the acknowledges and requests collide freely over a small pool of rows. Each cycle's outputs are judged against a bench model that decides from the record before the edge and applies the closes ahead of the open at the edge.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  // Bank counts the tracker is meant for; the top checks its parameter against this.
  localparam int unsigned TRK_MAX_BANKS = 8;

  // Update request for one bank slot, built by the top from the acknowledges.
  typedef struct packed {
    logic open_set;   // ACTIVE acknowledged for this bank
    logic open_clr;   // PRECHARGE or precharge-all acknowledged
  } trk_upd_t;
endpackage

// File: rtl/trk_bank_slot.sv
module trk_bank_slot #(
  parameter int unsigned ROW_W = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  sdram_trk_pkg::trk_upd_t upd,
  input  logic [ROW_W-1:0]     row_in,
  output logic                 is_open,
  output logic [ROW_W-1:0]     open_row
);
  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             row_en;

  // Closes apply first, an ACTIVE in the same cycle wins.
  always_comb begin
    open_d = open_q;
    if (upd.open_clr) open_d = 1'b0;
    if (upd.open_set) open_d = 1'b1;
  end

  assign row_en = upd.open_set;

  always_comb begin
    row_d = row_q;
    if (row_en) row_d = row_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      row_q <= '0;
    else if (row_en) row_q <= row_d;
  end

  assign is_open  = open_q;
  assign open_row = row_q;

  // R6 / R9: an acknowledged ACTIVE opens the slot with the supplied row
  assert_set_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd.open_set |=> (is_open && open_row == $past(row_in)));

  // R7 / R8: a close without a simultaneous ACTIVE leaves the slot closed
  assert_clr_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd.open_clr && !upd.open_set) |=> !is_open);

  // R6: the stored row moves only on an ACTIVE
  assert_row_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd.open_set |=> $stable(open_row));
endmodule

// File: rtl/trk_decide.sv
module trk_decide #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       req_valid,
  input  logic [BANK_W-1:0]          req_bank,
  input  logic [ROW_W-1:0]           req_row,
  input  logic                       ref_req,
  input  logic [NUM_BANKS-1:0]       bank_open,
  input  logic [NUM_BANKS*ROW_W-1:0] bank_rows,
  output logic                       need_act,
  output logic                       need_pre,
  output logic                       need_pre_all
);
  logic             sel_open;
  logic [ROW_W-1:0] sel_row;
  logic             row_match;

  always_comb begin
    sel_open = bank_open[req_bank];
    sel_row  = bank_rows[req_bank*ROW_W +: ROW_W];
  end

  assign row_match    = sel_open && (sel_row == req_row);
  assign need_act     = req_valid && !row_match;
  assign need_pre     = req_valid && sel_open && !row_match;
  assign need_pre_all = ref_req && (|bank_open);

  always_comb begin
    // R4: a precharge is always followed by an activation
    assert_pre_implies_act_R4: assert (!need_pre || need_act);
    // R11: no request, no access commands
    assert_idle_quiet_R11: assert (req_valid || (!need_act && !need_pre));
    // R5: nothing to close when every bank is idle
    assert_refresh_idle_R5: assert (|bank_open || !need_pre_all);
  end
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic              ref_req,
  input  logic              ack_act,
  input  logic              ack_pre,
  input  logic              ack_pre_all,
  input  logic [BANK_W-1:0] ack_bank,
  input  logic [ROW_W-1:0]  ack_row,
  output logic              need_act,
  output logic              need_pre,
  output logic              need_pre_all
);
  import sdram_trk_pkg::*;

  logic [NUM_BANKS-1:0]       bank_open;
  logic [NUM_BANKS*ROW_W-1:0] bank_rows;
  trk_upd_t                   upd [NUM_BANKS];

  initial begin
    assert_bank_count_cfg: assert (NUM_BANKS <= TRK_MAX_BANKS && (NUM_BANKS & (NUM_BANKS - 1)) == 0);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_comb begin
      upd[b].open_set = ack_act && (ack_bank == BANK_W'(b));
      upd[b].open_clr = ack_pre_all || (ack_pre && (ack_bank == BANK_W'(b)));
    end

    trk_bank_slot #(.ROW_W(ROW_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (upd[b]),
      .row_in   (ack_row),
      .is_open  (bank_open[b]),
      .open_row (bank_rows[b*ROW_W +: ROW_W])
    );
  end

  trk_decide #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_decide (
    .req_valid    (req_valid),
    .req_bank     (req_bank),
    .req_row      (req_row),
    .ref_req      (ref_req),
    .bank_open    (bank_open),
    .bank_rows    (bank_rows),
    .need_act     (need_act),
    .need_pre     (need_pre),
    .need_pre_all (need_pre_all)
  );

  // R8: precharge-all without an ACTIVE leaves no bank open
  assert_pre_all_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pre_all && !ack_act) |=> ($countones(bank_open) == 0));

  // R9: ACTIVE beside a precharge-all leaves exactly its own bank open
  assert_act_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pre_all && ack_act) |=> ($countones(bank_open) == 1));

  // R7: single-bank precharge never opens anything
  assert_pre_no_growth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pre && !ack_act && !ack_pre_all) |=>
      ($countones(bank_open) <= $past($countones(bank_open))));
endmodule

// File: tb/sdram_row_tracker_bench.sv
module sdram_row_tracker_bench;
  localparam int NB = 4;
  localparam int RW = 13;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, ref_req, ack_act, ack_pre, ack_pre_all;
  logic [BW-1:0] req_bank, ack_bank;
  logic [RW-1:0] req_row, ack_row;
  logic          need_act, need_pre, need_pre_all;

  int n_checks = 0;
  int n_fail   = 0;
  bit          m_open [NB];
  logic [RW-1:0] m_row [NB];

  always #4 clk = ~clk;

  sdram_row_tracker #(.NUM_BANKS(NB), .ROW_W(RW)) u_sdram_row_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_row(req_row), .ref_req(ref_req), .ack_act(ack_act), .ack_pre(ack_pre),
    .ack_pre_all(ack_pre_all), .ack_bank(ack_bank), .ack_row(ack_row),
    .need_act(need_act), .need_pre(need_pre), .need_pre_all(need_pre_all));

  function automatic logic [2:0] expect_cmd();
    logic hit, any;
    hit = m_open[req_bank] && (m_row[req_bank] == req_row);
    any = 1'b0;
    for (int b = 0; b < NB; b++) any |= m_open[b];
    return {req_valid && !hit, req_valid && m_open[req_bank] && !hit, ref_req && any};
  endfunction

  task automatic model_edge();
    for (int b = 0; b < NB; b++) begin
      if (ack_pre_all || (ack_pre && ack_bank == BW'(b))) m_open[b] = 1'b0;
      if (ack_act && ack_bank == BW'(b)) begin m_open[b] = 1'b1; m_row[b] = ack_row; end
    end
  endtask

  // Drive on the falling edge, check mid-phase, then let the rising edge update.
  task automatic step(input string tag, input bit rq, input int rb, input int rr,
                      input bit rf, input bit aa, input bit ap, input bit apa,
                      input int ab, input int ar);
    logic [2:0] exp, act;
    @(negedge clk);
    req_valid = rq; req_bank = BW'(rb); req_row = RW'(rr); ref_req = rf;
    ack_act = aa; ack_pre = ap; ack_pre_all = apa; ack_bank = BW'(ab); ack_row = RW'(ar);
    #1;
    exp = expect_cmd();
    act = {need_act, need_pre, need_pre_all};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {act,pre,pre_all} got %b expected %b", tag, act, exp);
    end
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd7;
    int unsigned r;
    for (int b = 0; b < NB; b++) begin m_open[b] = 1'b0; m_row[b] = '0; end
    rst_n = 1'b0;
    {req_valid, ref_req, ack_act, ack_pre, ack_pre_all} = '0;
    req_bank = '0; ack_bank = '0; req_row = '0; ack_row = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: all banks closed after reset
    step("R1 req", 1, 2, 99, 1, 0, 0, 0, 0, 0);
    step("R11 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 open bank0 row 5, R10 same-cycle request sees the old record (R2)
    step("R10 R2", 1, 0, 5, 0, 1, 0, 0, 0, 5);
    step("R3 hit", 1, 0, 5, 1, 0, 0, 0, 0, 0);
    step("R4 conflict", 1, 0, 8191, 0, 1, 0, 0, 1, 77);
    step("R6 bank1", 1, 1, 77, 0, 0, 0, 0, 0, 0);
    // R7 close bank0 only
    step("R7 pre", 1, 0, 5, 0, 0, 1, 0, 0, 0);
    step("R7 closed", 1, 0, 5, 0, 0, 0, 0, 0, 0);
    step("R7 kept", 1, 1, 77, 1, 0, 0, 0, 0, 0);
    // R9 ACTIVE with precharge-all on bank3
    step("R9 both", 0, 0, 0, 0, 1, 0, 1, 3, 12);
    step("R9 other", 1, 1, 77, 0, 0, 0, 0, 0, 0);
    step("R9 act", 1, 3, 12, 1, 0, 0, 0, 0, 0);
    // R9 ACTIVE with single precharge same bank
    step("R9 pre+act", 1, 3, 13, 0, 1, 1, 0, 3, 13);
    step("R9 row", 1, 3, 13, 0, 0, 0, 0, 0, 0);
    // R8 precharge-all then refresh sees nothing open (R5)
    step("R8 pre_all", 0, 0, 0, 1, 0, 0, 1, 0, 0);
    step("R5 none", 1, 3, 13, 1, 0, 0, 0, 0, 0);

    // Random mix over a small row pool
    for (int i = 0; i < 3000; i++) begin
      int rowp [4] = '{0, 1, 2, 8191};
      r = $urandom(seed + i);
      step("R2-rand R3 R4 R5 R8", r[0], int'(r[2:1]), rowp[r[4:3]], r[5],
           r[7:6] == 2'b11, r[9:8] == 2'b11, r[13:10] == 4'hF,
           int'(r[15:14]), rowp[r[17:16]]);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule